// File: doc/BRIEF.md
# Correlating Two-Level Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It keeps a table of small saturating counters and a shift register holding the outcomes of the most recently resolved branches. The counter that serves a branch is chosen from low bits of the branch address together with that recent-outcome history. A branch address therefore owns one counter for each possible history value, and the same branch can be predicted differently depending on the path that led to it.

A fetch stage presents a PC on the lookup side. In the same cycle it receives a direction guess and the history value used to make that guess. When the branch resolves, the pipeline returns the PC, that same history value and the real outcome on the update side. The block then trains exactly one counter and shifts the outcome into the history.

An elaboration parameter selects how the table index is formed. In the default mode the address bits and the history bits are placed side by side, so each address gets its own group of counters. In the alternative mode the history is XOR-folded into the address bits and a smaller table is indexed.

Top module: `corr_branch_pred`

## Requirements
- R1: While `rst` is high, the history register goes to zero and every counter goes to the weakly-not-taken value 1 (binary 01). Directly after reset, `lk_hist` reads 0 and every lookup predicts not-taken.
- R2: Each cycle with `upd_valid` high shifts `upd_taken` into bit 0 of the history, with 1 meaning taken, and the older bits move up by one place. With `upd_valid` low the history holds its value.
- R3: `lk_taken` is 1 exactly when the selected counter is at or above 2^(CTR_BITS-1), which is 2 or 3 for 2-bit counters.
- R4: A counter goes up by one on a taken update and down by one on a not-taken update, and it saturates at 3 and at 0. After three taken updates, one not-taken update leaves the prediction taken and a second one turns it to not-taken.
- R5: An update changes only the counter it selects. Lookups of the same address under the other history values, and lookups of other addresses, return unchanged results.
- R6: In concatenation mode the index is {history, PC[PC_SHIFT+ADDR_BITS-1:PC_SHIFT]}, with the history in the upper bits. PC bits outside that slice have no effect, so PCs that differ only above or below the slice share a counter.
- R7: In XOR mode the index is PC[PC_SHIFT+ADDR_BITS-1:PC_SHIFT] XOR the zero-extended history, and the table holds 2^ADDR_BITS counters. Two (address, history) pairs with the same XOR result share a counter.
- R8: If a lookup and an update select the same counter in the same cycle, the lookup returns the prediction from the counter value before the update. The trained value is visible from the next cycle on.
- R9: The update port selects its counter with `upd_hist`, not with the current history register. The lookup side always uses the current history register.
- R10: Starting from reset, a single taken update to a counter makes that counter predict taken.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| lk_pc | input | PC_W | Fetch PC to predict |
| lk_taken | output | 1 | Predicted direction, combinational from `lk_pc` and the history register |
| lk_hist | output | HIST_BITS | History value used for this prediction; the caller keeps it for the update |
| upd_valid | input | 1 | A resolved branch is presented this cycle |
| upd_pc | input | PC_W | PC of the resolved branch |
| upd_hist | input | HIST_BITS | History value returned with the prediction for this branch |
| upd_taken | input | 1 | Resolved outcome, 1 = taken |

## Verification
A lookup is purely combinational, so `lk_taken` and `lk_hist` are valid in the same cycle that `lk_pc` is driven. The bench drives its inputs on the falling edge and samples the outputs one nanosecond later. An update is committed at the next rising edge, so both the trained counter and the shifted history can be seen from the following falling edge. Each scenario therefore waits one full cycle after an update before it reads results. The same-cycle collision case is the only one that reads a lookup while an update is still pending: it samples before the rising edge and expects the old value. A second instance in XOR mode receives the same stimulus, and each instance is compared against its own model of the counters and the history.

// File: rtl/bp_pkg.sv
package bp_pkg;
   // How the counter index is built from address bits and history bits.
   typedef enum logic {
      MAP_CONCAT = 1'b0,   // {history, address}: one group of counters per address
      MAP_XOR    = 1'b1    // address ^ history: shared, smaller table
   } map_mode_e;
endpackage

// File: rtl/bp_hist_reg.sv
module bp_hist_reg #(
   parameter int HIST_BITS = 2
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 shift_en,
   input  logic                 bit_in,
   output logic [HIST_BITS-1:0] hist
);
   logic [HIST_BITS-1:0] hist_q;

   generate
      if (HIST_BITS == 1) begin : g_single
         always_ff @(posedge clk) begin
            if (rst)           hist_q <= '0;
            else if (shift_en) hist_q <= bit_in;
         end
      end else begin : g_multi
         always_ff @(posedge clk) begin
            if (rst)           hist_q <= '0;
            else if (shift_en) hist_q <= {hist_q[HIST_BITS-2:0], bit_in};
         end
      end
   endgenerate

   assign hist = hist_q;
endmodule

// File: rtl/bp_index.sv
module bp_index
   import bp_pkg::*;
#(
   parameter int        ADDR_BITS = 4,
   parameter int        HIST_BITS = 2,
   parameter map_mode_e MAP_MODE  = MAP_CONCAT,
   parameter int        IDX_W     = (MAP_MODE == MAP_CONCAT) ? ADDR_BITS + HIST_BITS : ADDR_BITS
) (
   input  logic [ADDR_BITS-1:0] addr,
   input  logic [HIST_BITS-1:0] hist,
   output logic [IDX_W-1:0]     idx
);
   generate
      if (MAP_MODE == MAP_CONCAT) begin : g_concat
         assign idx = {hist, addr};
      end else begin : g_xor
         assign idx = addr ^ IDX_W'(hist);
      end
   endgenerate
endmodule

// File: rtl/bp_ctr_table.sv
module bp_ctr_table #(
   parameter int IDX_W    = 6,
   parameter int CTR_BITS = 2
) (
   input  logic                clk,
   input  logic                rst,
   input  logic [IDX_W-1:0]    rd_idx,
   output logic [CTR_BITS-1:0] rd_ctr,
   input  logic                wr_en,
   input  logic [IDX_W-1:0]    wr_idx,
   input  logic                wr_taken
);
   localparam int                  DEPTH  = 2 ** IDX_W;
   localparam logic [CTR_BITS-1:0] SAT_HI = '1;
   localparam logic [CTR_BITS-1:0] INIT   = CTR_BITS'((1 << (CTR_BITS - 1)) - 1);

   logic [CTR_BITS-1:0] ctr_q [DEPTH];

   generate
      for (genvar e = 0; e < DEPTH; e++) begin : g_entry
         logic hit;
         assign hit = wr_en && (wr_idx == IDX_W'(e));
         always_ff @(posedge clk) begin
            if (rst) begin
               ctr_q[e] <= INIT;
            end else if (hit) begin
               if (wr_taken && (ctr_q[e] != SAT_HI))
                  ctr_q[e] <= ctr_q[e] + CTR_BITS'(1);
               else if (!wr_taken && (ctr_q[e] != '0))
                  ctr_q[e] <= ctr_q[e] - CTR_BITS'(1);
            end
         end
      end
   endgenerate

   // Read side sees register state, so a same-cycle write is not yet visible.
   assign rd_ctr = ctr_q[rd_idx];
endmodule

// File: rtl/corr_branch_pred.sv
module corr_branch_pred
   import bp_pkg::*;
#(
   parameter int        PC_W      = 32,
   parameter int        PC_SHIFT  = 2,
   parameter int        ADDR_BITS = 4,
   parameter int        HIST_BITS = 2,
   parameter int        CTR_BITS  = 2,
   parameter map_mode_e MAP_MODE  = MAP_CONCAT
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic [PC_W-1:0]      lk_pc,
   output logic                 lk_taken,
   output logic [HIST_BITS-1:0] lk_hist,
   input  logic                 upd_valid,
   input  logic [PC_W-1:0]      upd_pc,
   input  logic [HIST_BITS-1:0] upd_hist,
   input  logic                 upd_taken
);
   localparam int IDX_W = (MAP_MODE == MAP_CONCAT) ? ADDR_BITS + HIST_BITS : ADDR_BITS;
   localparam logic [CTR_BITS-1:0] THRESH = CTR_BITS'(1) << (CTR_BITS - 1);

   // Elaboration-time parameter checks
   generate
      if (CTR_BITS < 1)
         begin : g_bad_ctr  $error("CTR_BITS must be at least 1"); end
      if (HIST_BITS < 1)
         begin : g_bad_hist $error("HIST_BITS must be at least 1"); end
      if (ADDR_BITS < 1 || PC_SHIFT < 0 || PC_SHIFT + ADDR_BITS > PC_W)
         begin : g_bad_addr $error("address slice does not fit in PC_W"); end
      if (MAP_MODE == MAP_XOR && HIST_BITS > ADDR_BITS)
         begin : g_bad_xor  $error("XOR mode needs HIST_BITS <= ADDR_BITS"); end
      if (IDX_W > 12)
         begin : g_bad_size $error("counter table too large"); end
   endgenerate

   logic [ADDR_BITS-1:0] lk_addr, upd_addr;
   logic [IDX_W-1:0]     lk_idx, upd_idx;
   logic [CTR_BITS-1:0]  lk_ctr;
   logic                 unused_pc_bits;

   assign lk_addr        = lk_pc[PC_SHIFT +: ADDR_BITS];
   assign upd_addr       = upd_pc[PC_SHIFT +: ADDR_BITS];
   assign unused_pc_bits = ^{lk_pc, upd_pc};

   bp_hist_reg #(.HIST_BITS(HIST_BITS)) u_hist (
      .clk      (clk),
      .rst      (rst),
      .shift_en (upd_valid),
      .bit_in   (upd_taken),
      .hist     (lk_hist)
   );

   bp_index #(.ADDR_BITS(ADDR_BITS), .HIST_BITS(HIST_BITS),
              .MAP_MODE(MAP_MODE), .IDX_W(IDX_W)) u_lk_idx (
      .addr (lk_addr),
      .hist (lk_hist),
      .idx  (lk_idx)
   );

   bp_index #(.ADDR_BITS(ADDR_BITS), .HIST_BITS(HIST_BITS),
              .MAP_MODE(MAP_MODE), .IDX_W(IDX_W)) u_upd_idx (
      .addr (upd_addr),
      .hist (upd_hist),
      .idx  (upd_idx)
   );

   bp_ctr_table #(.IDX_W(IDX_W), .CTR_BITS(CTR_BITS)) u_table (
      .clk      (clk),
      .rst      (rst),
      .rd_idx   (lk_idx),
      .rd_ctr   (lk_ctr),
      .wr_en    (upd_valid),
      .wr_idx   (upd_idx),
      .wr_taken (upd_taken)
   );

   assign lk_taken = (lk_ctr >= THRESH);
endmodule

// File: rtl/bp_checker.sv
module bp_checker #(
   parameter int PC_W      = 32,
   parameter int HIST_BITS = 2
) (
   input logic                 clk,
   input logic                 rst,
   input logic [PC_W-1:0]      lk_pc,
   input logic                 lk_taken,
   input logic [HIST_BITS-1:0] lk_hist,
   input logic                 upd_valid,
   input logic [PC_W-1:0]      upd_pc,
   input logic [HIST_BITS-1:0] upd_hist,
   input logic                 upd_taken
);
   logic unused_chk;
   assign unused_chk = ^{upd_pc, upd_hist};

   // R1: first cycle out of reset shows a clear history and a not-taken guess
   assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
      $fell(rst) |-> (lk_hist == '0 && !lk_taken));

   // R2: an update shifts its outcome into the low end of the history
   assert_hist_shift_R2: assert property (@(posedge clk) disable iff (rst)
      upd_valid |=> (lk_hist == HIST_BITS'({$past(lk_hist), $past(upd_taken)})));

   // R2: no update, no history change
   assert_hist_hold_R2: assert property (@(posedge clk) disable iff (rst)
      !upd_valid |=> $stable(lk_hist));

   // R5: without an update in between, the same lookup gives the same answer
   assert_pred_stable_R5: assert property (@(posedge clk) disable iff (rst)
      (!$past(upd_valid) && $stable(lk_pc) && $stable(lk_hist)) |-> $stable(lk_taken));
endmodule

bind corr_branch_pred bp_checker #(.PC_W(PC_W), .HIST_BITS(HIST_BITS)) u_chk (.*);

// File: tb/sim_corr_branch_pred.sv
`timescale 1ns/1ps
module sim_corr_branch_pred;
   import bp_pkg::*;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [31:0] lk_pc = '0;
   logic        upd_valid = 1'b0;
   logic [31:0] upd_pc = '0;
   logic [1:0]  upd_hist = '0;
   logic        upd_taken = 1'b0;
   logic        c_taken, x_taken;
   logic [1:0]  c_hist, x_hist;

   always #5 clk = ~clk;

   corr_branch_pred #(.MAP_MODE(MAP_CONCAT)) u0 (
      .clk(clk), .rst(rst), .lk_pc(lk_pc), .lk_taken(c_taken), .lk_hist(c_hist),
      .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_hist(upd_hist), .upd_taken(upd_taken));

   corr_branch_pred #(.MAP_MODE(MAP_XOR)) u1 (
      .clk(clk), .rst(rst), .lk_pc(lk_pc), .lk_taken(x_taken), .lk_hist(x_hist),
      .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_hist(upd_hist), .upd_taken(upd_taken));

   // Reference state built from the requirements
   int         ref_c [64];
   int         ref_x [16];
   logic [1:0] ref_hist;
   int         n_checks = 0;
   int         n_fails  = 0;
   bit         finished = 1'b0;

   localparam logic [31:0] SCRATCH = 32'h0000_003C;   // address bits = 15

   function automatic int idx_c(logic [31:0] pc, logic [1:0] h);
      return int'({h, pc[5:2]});
   endfunction
   function automatic int idx_x(logic [31:0] pc, logic [1:0] h);
      return int'(pc[5:2] ^ {2'b00, h});
   endfunction

   task automatic check(bit ok, string req, int act, int exp);
      n_checks++;
      if (!ok) begin
         n_fails++;
         $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   task automatic ref_reset();
      for (int i = 0; i < 64; i++) ref_c[i] = 1;
      for (int i = 0; i < 16; i++) ref_x[i] = 1;
      ref_hist = 2'b00;
   endtask

   function automatic int sat(int v, logic t);
      if (t && v < 3) return v + 1;
      if (!t && v > 0) return v - 1;
      return v;
   endfunction

   // One update; committed at the next rising edge
   task automatic apply_upd(logic [31:0] pc, logic [1:0] h, logic t);
      @(negedge clk);
      upd_valid = 1'b1; upd_pc = pc; upd_hist = h; upd_taken = t;
      ref_c[idx_c(pc, h)] = sat(ref_c[idx_c(pc, h)], t);
      ref_x[idx_x(pc, h)] = sat(ref_x[idx_x(pc, h)], t);
      ref_hist = {ref_hist[0], t};
      @(negedge clk);
      upd_valid = 1'b0;
   endtask

   // Lookup checked against both reference tables
   task automatic look(logic [31:0] pc, string req);
      @(negedge clk);
      lk_pc = pc;
      #1;
      check(c_taken == (ref_c[idx_c(pc, ref_hist)] >= 2), {req, " concat"},
            int'(c_taken), int'(ref_c[idx_c(pc, ref_hist)] >= 2));
      check(x_taken == (ref_x[idx_x(pc, ref_hist)] >= 2), {req, " xor"},
            int'(x_taken), int'(ref_x[idx_x(pc, ref_hist)] >= 2));
      check(c_hist == ref_hist && x_hist == ref_hist, {req, " hist"},
            int'(c_hist), int'(ref_hist));
   endtask

   // Steer the global history to v via two updates on a scratch branch
   task automatic set_hist(logic [1:0] v);
      apply_upd(SCRATCH, 2'b11, v[1]);
      apply_upd(SCRATCH, 2'b11, v[0]);
   endtask

   task automatic t_reset_R1();
      look(32'h0000_0004, "R1");
      look(32'h0000_0038, "R1");
      check(c_taken == 1'b0, "R1 literal", int'(c_taken), 0);
   endtask

   task automatic t_first_taken_R10();
      apply_upd(32'h0000_0004, 2'b00, 1'b1);          // addr 1, hist 0
      set_hist(2'b00);
      look(32'h0000_0004, "R10");
      check(c_taken == 1'b1, "R10 literal", int'(c_taken), 1);
   endtask

   task automatic t_history_R2();
      set_hist(2'b10);
      look(32'h0000_0010, "R2");
      check(c_hist == 2'b10, "R2 literal", int'(c_hist), 2);
      @(negedge clk); @(negedge clk);                  // idle cycles: hold
      look(32'h0000_0010, "R2 hold");
   endtask

   task automatic t_saturate_R4();
      logic [31:0] pc = 32'h0000_0008;                 // addr 2
      for (int i = 0; i < 4; i++) apply_upd(pc, 2'b00, 1'b1);
      apply_upd(pc, 2'b00, 1'b0);
      set_hist(2'b00);
      look(pc, "R4 one miss");
      check(c_taken == 1'b1, "R4 still taken", int'(c_taken), 1);
      apply_upd(pc, 2'b00, 1'b0);
      set_hist(2'b00);
      look(pc, "R4 two misses");
      check(c_taken == 1'b0, "R4 flipped", int'(c_taken), 0);
      for (int i = 0; i < 4; i++) apply_upd(pc, 2'b00, 1'b0);
      apply_upd(pc, 2'b00, 1'b1);
      set_hist(2'b00);
      look(pc, "R4 floor");
      check(c_taken == 1'b0, "R4 floor literal", int'(c_taken), 0);
   endtask

   task automatic t_isolation_R5();
      // addr 1 at hist 0 was trained taken; other columns and rows untouched
      for (int h = 1; h < 4; h++) begin
         set_hist(2'(h));
         look(32'h0000_0004, "R5 column");
         check(c_taken == 1'b0, "R5 column literal", int'(c_taken), 0);
      end
      set_hist(2'b00);
      look(32'h0000_0018, "R5 row");
   endtask

   task automatic t_alias_R6();
      set_hist(2'b00);
      look(32'h0000_0044, "R6 high bits");             // same slice as 0x04
      check(c_taken == 1'b1, "R6 high literal", int'(c_taken), 1);
      look(32'h8000_0007, "R6 low bits");
      check(c_taken == 1'b1, "R6 low literal", int'(c_taken), 1);
   endtask

   task automatic t_xor_R7();
      apply_upd(32'h0000_0014, 2'b00, 1'b1);           // addr 5, hist 0 -> slot 5
      apply_upd(32'h0000_0014, 2'b00, 1'b1);
      set_hist(2'b01);
      look(32'h0000_0010, "R7");                       // addr 4 ^ 1 = 5
      check(x_taken == 1'b1, "R7 shared slot", int'(x_taken), 1);
      check(c_taken == 1'b0, "R7 concat separate", int'(c_taken), 0);
   endtask

   task automatic t_collide_R8();
      logic [31:0] pc = 32'h0000_0024;                 // addr 9, fresh
      set_hist(2'b00);
      @(negedge clk);
      lk_pc = pc;
      upd_valid = 1'b1; upd_pc = pc; upd_hist = 2'b00; upd_taken = 1'b1;
      #1;
      check(c_taken == 1'b0, "R8 pre-update concat", int'(c_taken), 0);
      check(x_taken == 1'b0, "R8 pre-update xor", int'(x_taken), 0);
      ref_c[idx_c(pc, 2'b00)] = sat(ref_c[idx_c(pc, 2'b00)], 1'b1);
      ref_x[idx_x(pc, 2'b00)] = sat(ref_x[idx_x(pc, 2'b00)], 1'b1);
      ref_hist = {ref_hist[0], 1'b1};
      @(negedge clk);
      upd_valid = 1'b0;
      set_hist(2'b00);
      look(pc, "R8 after");
      check(c_taken == 1'b1, "R8 after literal", int'(c_taken), 1);
   endtask

   task automatic t_upd_hist_R9();
      logic [31:0] pc = 32'h0000_0028;                 // addr 10
      set_hist(2'b11);
      apply_upd(pc, 2'b10, 1'b1);                      // trains column 2
      set_hist(2'b11);
      look(pc, "R9 current column");
      check(c_taken == 1'b0, "R9 current literal", int'(c_taken), 0);
      set_hist(2'b10);
      look(pc, "R9 named column");
      check(c_taken == 1'b1, "R9 named literal", int'(c_taken), 1);
   endtask

   task automatic t_taken_R3();
      // threshold: counter 1 -> not taken, 2 -> taken
      logic [31:0] pc = 32'h0000_0030;                 // addr 12
      set_hist(2'b01);
      look(pc, "R3 at 1");
      apply_upd(pc, 2'b01, 1'b1);
      set_hist(2'b01);
      look(pc, "R3 at 2");
      check(c_taken == 1'b1, "R3 literal", int'(c_taken), 1);
   endtask

   initial begin
      ref_reset();
      repeat (3) @(negedge clk);
      rst = 1'b0;
      t_reset_R1();
      t_first_taken_R10();
      t_history_R2();
      t_saturate_R4();
      t_isolation_R5();
      t_alias_R6();
      t_xor_R7();
      t_collide_R8();
      t_upd_hist_R9();
      t_taken_R3();
      if (!finished) begin
         finished = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
         $finish;
      end
   end

   initial begin
      #500000;
      if (!finished) begin
         finished = 1'b1;
         n_checks++;
         n_fails++;
         $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
         $finish;
      end
   end
endmodule